// File: doc/BRIEF.md
# Snoop write-back bus sequencer

This block is the bus-side sequencer of a write-back cache. It issues burst line-fill reads on behalf of the cache. When an external agent snoops a line that is held modified, the block signals the hit. If the external agent then forces the processor off the bus, the block abandons the fill in flight. Once the bus is handed back, it writes the dirty line out first and then reissues the abandoned read at the same address.

Line-fill requests enter through a valid/ready port. A request is taken on a clock where both `req_valid` and `req_ready` are high. `req_ready` drops whenever the block is busy, the external agent holds the address bus, a back-off is in force, or a write-back is still owed. The requester must hold `req_valid` and `req_addr` stable until the request is taken. The cache arrays and the line-state storage stay outside the block. A combinational lookup port reports whether the snooped line is modified. A one-cycle update pulse tells the line store the new state of the snooped line once it has been written back.

All bus strobes are active low. The block samples its inputs on the rising clock edge. Its bus outputs change only on that edge.

Top module: `snoop_wb_sequencer`

## Requirements
- R1: After reset, `bus_start_n` and `snoop_mod_n` are 1, `fill_done` and `upd_valid` are 0, and `req_ready` is 1 while `addr_hold` is 0 and `backoff_n` is 1.
- R2: A request taken at a clock edge produces, in the cycle that follows, `bus_start_n`=0 with `bus_write`=0 and `bus_addr` equal to the request address. Bus cycles start in the order their requests were taken.
- R3: `req_ready` is 0 while `addr_hold` is 1, while `backoff_n` is 0, and while a fill or write-back is in progress.
- R4: When `snoop_strobe_n`=0 and `addr_hold`=1 are sampled and `lk_modified`=1, `snoop_mod_n` goes to 0 in the next cycle. If `lk_modified`=0, `snoop_mod_n` stays 1.
- R5: When `backoff_n`=0 is sampled during a fill, the fill is abandoned. `fill_done` does not pulse for it, and `bus_start_n` stays 1 in every cycle that follows an edge where `backoff_n`=0 was sampled.
- R6: A pending write-back starts in the cycle right after the first edge where both `backoff_n`=1 and `addr_hold`=0 are sampled, whichever of the two was released last. It shows `bus_start_n`=0, `bus_write`=1, and `bus_addr` equal to the snooped address with its low LINE_OFF bits cleared.
- R7: A burst ends only at an edge where `xfer_rdy_n`=0 and `xfer_last_n`=0 are both sampled. Ready beats with `xfer_last_n`=1 do not end it. A burst is BEATS transfers long.
- R8: If a fill was abandoned, the cycle after the write-back ends shows `bus_start_n`=0, `bus_write`=0 and `bus_addr` equal to the abandoned address. `snoop_mod_n` is back at 1 in that same cycle.
- R9: In the cycle after the write-back ends, `upd_valid` is 1 for exactly one cycle and `upd_line` carries the snooped line. `upd_inval` is 1 (line becomes invalid) if `snoop_inval` was 1 when the snoop was sampled, and 0 (line becomes shared) otherwise.
- R10: A fill that is not abandoned completes at its burst end, and `fill_done` is 1 for one cycle in the cycle that follows.
- R11: A modified hit taken while idle is written back once `addr_hold` is released, with no back-off needed. Afterwards no read is reissued and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Line-fill request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | AW | Line-fill address |
| fill_done | output | 1 | One-cycle pulse: fill burst completed |
| bus_start_n | output | 1 | Bus cycle start strobe, active low |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Bus address |
| snoop_mod_n | output | 1 | Snoop hit a modified line, active low |
| backoff_n | input | 1 | Back-off from external agent, active low |
| addr_hold | input | 1 | External agent holds the address bus |
| snoop_strobe_n | input | 1 | Snoop address valid strobe, active low |
| snoop_addr | input | AW | Snooped address |
| snoop_inval | input | 1 | Snoop asks for invalidation |
| xfer_rdy_n | input | 1 | Transfer ready, active low |
| xfer_last_n | input | 1 | Last transfer of burst, active low |
| lk_line | output | AW-LINE_OFF | Line index sent to the line-state lookup |
| lk_modified | input | 1 | Looked-up line is modified |
| upd_valid | output | 1 | Line-state update pulse |
| upd_inval | output | 1 | 1 = mark invalid, 0 = mark shared |
| upd_line | output | AW-LINE_OFF | Line to update |

## Verification
The hardest state to reach is a modified snoop hit that lands in the middle of a partly finished fill. The back-off must then arrive mid-burst, and the two bus-release signals must drop in either order. The stimulus starts a fill and delivers one beat. It raises the address hold, strobes a snoop whose line the stand-in lookup reports as modified, and then asserts back-off. It releases hold and back-off in both orders across two runs, timing the write-back strobe against the later release. A scoreboard of expected bus cycles (direction and address) confirms that the write-back comes before the replayed read.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FADR = 3'd1,
    ST_FDAT = 3'd2,
    ST_HOLD = 3'd3,
    ST_WADR = 3'd4,
    ST_WDAT = 3'd5
  } seq_state_t;
endpackage

// File: rtl/sws_snoop_tracker.sv
module sws_snoop_tracker #(
  parameter int AW       = 32,
  parameter int LINE_OFF = 4,
  localparam int LW      = AW - LINE_OFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snoop_strobe_n,
  input  logic          addr_hold,
  input  logic [AW-1:0] snoop_addr,
  input  logic          snoop_inval,
  input  logic          lk_modified,
  input  logic          wb_done,
  output logic [LW-1:0] lk_line,
  output logic          wb_pend,
  output logic          snoop_mod_n,
  output logic [AW-1:0] wb_addr,
  output logic          upd_valid,
  output logic          upd_inval,
  output logic [LW-1:0] upd_line
);
  logic [LW-1:0] line_q;
  logic          inv_q;
  logic          take_hit;

  assign lk_line  = snoop_addr[AW-1:LINE_OFF];
  assign take_hit = !wb_pend && !snoop_strobe_n && addr_hold && lk_modified;
  assign wb_addr  = {line_q, {LINE_OFF{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_pend     <= 1'b0;
      snoop_mod_n <= 1'b1;
      line_q      <= '0;
      inv_q       <= 1'b0;
      upd_valid   <= 1'b0;
      upd_inval   <= 1'b0;
      upd_line    <= '0;
    end else begin
      upd_valid <= 1'b0;
      if (wb_done) begin
        wb_pend     <= 1'b0;
        snoop_mod_n <= 1'b1;
        upd_valid   <= 1'b1;
        upd_inval   <= inv_q;
        upd_line    <= line_q;
      end else if (take_hit) begin
        wb_pend     <= 1'b1;
        snoop_mod_n <= 1'b0;
        line_q      <= lk_line;
        inv_q       <= snoop_inval;
      end
    end
  end

  assert_hitm_on_mod_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_pend && !snoop_strobe_n && addr_hold && lk_modified) |=> !snoop_mod_n);

  assert_upd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);
endmodule

// File: rtl/sws_beat_counter.sv
module sws_beat_counter #(
  parameter int BEATS = 4,
  localparam int CW   = $clog2(BEATS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_data,
  input  logic xfer_rdy_n,
  input  logic xfer_last_n,
  output logic burst_end
);
  logic [CW-1:0] cnt_q;

  assign burst_end = in_data && !xfer_rdy_n && !xfer_last_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!in_data)            cnt_q <= '0;
    else if (!xfer_rdy_n)         cnt_q <= cnt_q + 1'b1;
  end

  assert_burst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |-> (cnt_q == CW'(BEATS - 1)));
endmodule

// File: rtl/sws_bus_fsm.sv
module sws_bus_fsm
  import sws_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  input  logic          backoff_n,
  input  logic          addr_hold,
  input  logic          wb_pend,
  input  logic [AW-1:0] wb_addr,
  input  logic          burst_end,
  output seq_state_t    state,
  output logic          in_data,
  output logic          wb_done,
  output logic          fill_done,
  output logic          bus_start_n,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr
);
  seq_state_t    st_q, st_nx;
  logic [AW-1:0] fill_addr_q;
  logic          replay_q;
  logic          released, take_req, set_replay, clr_replay, fill_end;

  assign released  = backoff_n && !addr_hold;
  assign req_ready = (st_q == ST_IDLE) && released && !wb_pend;
  assign state     = st_q;
  assign in_data   = (st_q == ST_FDAT) || (st_q == ST_WDAT);

  always_comb begin
    st_nx      = st_q;
    take_req   = 1'b0;
    set_replay = 1'b0;
    clr_replay = 1'b0;
    wb_done    = 1'b0;
    fill_end   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wb_pend && released) st_nx = ST_WADR;
        else if (req_valid && req_ready) begin
          st_nx    = ST_FADR;
          take_req = 1'b1;
        end
      end
      ST_FADR: begin
        if (!backoff_n) begin
          st_nx      = ST_HOLD;
          set_replay = 1'b1;
        end else st_nx = ST_FDAT;
      end
      ST_FDAT: begin
        if (!backoff_n) begin
          st_nx      = ST_HOLD;
          set_replay = 1'b1;
        end else if (burst_end) begin
          st_nx    = ST_IDLE;
          fill_end = 1'b1;
        end
      end
      ST_HOLD: begin
        if (released) begin
          if (wb_pend) st_nx = ST_WADR;
          else if (replay_q) begin
            st_nx      = ST_FADR;
            clr_replay = 1'b1;
          end else st_nx = ST_IDLE;
        end
      end
      ST_WADR: begin
        if (!backoff_n) st_nx = ST_HOLD;
        else            st_nx = ST_WDAT;
      end
      ST_WDAT: begin
        if (!backoff_n) st_nx = ST_HOLD;
        else if (burst_end) begin
          wb_done = 1'b1;
          if (replay_q) begin
            st_nx      = ST_FADR;
            clr_replay = 1'b1;
          end else st_nx = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      fill_addr_q <= '0;
      replay_q    <= 1'b0;
      fill_done   <= 1'b0;
      bus_addr    <= '0;
    end else begin
      st_q      <= st_nx;
      fill_done <= fill_end;
      if (take_req)        fill_addr_q <= req_addr;
      if (set_replay)      replay_q    <= 1'b1;
      else if (clr_replay) replay_q    <= 1'b0;
      if (st_nx == ST_WADR)      bus_addr <= wb_addr;
      else if (st_nx == ST_FADR) bus_addr <= take_req ? req_addr : fill_addr_q;
    end
  end

  assign bus_start_n = !((st_q == ST_FADR) || (st_q == ST_WADR));
  assign bus_write   = (st_q == ST_WADR) || (st_q == ST_WDAT);

  assert_wb_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WADR) |-> ($past(backoff_n) && !$past(addr_hold)));

  assert_no_start_in_backoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !backoff_n |=> bus_start_n);

  assert_ready_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> !req_ready);
endmodule

// File: rtl/snoop_wb_sequencer.sv
module snoop_wb_sequencer
  import sws_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LINE_OFF = 4,
  parameter int BEATS    = 4,
  localparam int LW      = AW - LINE_OFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          fill_done,
  output logic          bus_start_n,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          snoop_mod_n,
  input  logic          backoff_n,
  input  logic          addr_hold,
  input  logic          snoop_strobe_n,
  input  logic [AW-1:0] snoop_addr,
  input  logic          snoop_inval,
  input  logic          xfer_rdy_n,
  input  logic          xfer_last_n,
  output logic [LW-1:0] lk_line,
  input  logic          lk_modified,
  output logic          upd_valid,
  output logic          upd_inval,
  output logic [LW-1:0] upd_line
);
  seq_state_t    seq_state;
  logic          wb_pend, wb_done, burst_end, in_data;
  logic [AW-1:0] wb_addr;

  sws_snoop_tracker #(.AW(AW), .LINE_OFF(LINE_OFF)) u_snoop (
    .clk, .rst_n, .snoop_strobe_n, .addr_hold, .snoop_addr, .snoop_inval,
    .lk_modified, .wb_done, .lk_line, .wb_pend, .snoop_mod_n, .wb_addr,
    .upd_valid, .upd_inval, .upd_line
  );

  sws_beat_counter #(.BEATS(BEATS)) u_beats (
    .clk, .rst_n, .in_data, .xfer_rdy_n, .xfer_last_n, .burst_end
  );

  sws_bus_fsm #(.AW(AW)) u_fsm (
    .clk, .rst_n, .req_valid, .req_addr, .req_ready, .backoff_n, .addr_hold,
    .wb_pend, .wb_addr, .burst_end, .state(seq_state), .in_data, .wb_done,
    .fill_done, .bus_start_n, .bus_write, .bus_addr
  );

  assert_mod_released_at_replay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_FADR && $past(seq_state) == ST_WDAT) |-> snoop_mod_n);
endmodule

// File: tb/snoop_wb_sequencer_tb.sv
module snoop_wb_sequencer_tb;
  localparam int AW = 32, LOFF = 4, BEATS = 4, LW = AW - LOFF;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, fill_done;
  logic [AW-1:0] req_addr = '0, bus_addr, snoop_addr = '0;
  logic bus_start_n, bus_write, snoop_mod_n;
  logic backoff_n = 1, addr_hold = 0, snoop_strobe_n = 1, snoop_inval = 0;
  logic xfer_rdy_n = 1, xfer_last_n = 1;
  logic [LW-1:0] lk_line, upd_line, mod_line = '0;
  logic mod_en = 0, lk_modified, upd_valid, upd_inval;

  assign lk_modified = mod_en && (lk_line == mod_line);

  always #4 clk = ~clk;

  snoop_wb_sequencer #(.AW(AW), .LINE_OFF(LOFF), .BEATS(BEATS)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit wr; logic [AW-1:0] a; } bus_item_t;
  bus_item_t exp_q[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_cycle(bit wr, logic [AW-1:0] a);
    bus_item_t it;
    it.wr = wr; it.a = a;
    exp_q.push_back(it);
  endtask

  // scoreboard monitor: every bus cycle start is matched against the queue (R2, R6, R8)
  always @(negedge clk) begin
    if (rst_n && !done && bus_start_n == 1'b0) begin
      if (exp_q.size() == 0) chk(0, "R2", "unexpected bus start addr", bus_addr, 0);
      else begin
        bus_item_t it;
        it = exp_q.pop_front();
        chk(bus_write == it.wr, "R2", "bus cycle direction", bus_write, it.wr);
        chk(bus_addr == it.a, "R2", "bus cycle address", bus_addr, it.a);
      end
    end
  end

  task automatic request(logic [AW-1:0] a);
    req_valid = 1; req_addr = a;
    chk(req_ready == 1, "R2", "ready before request", req_ready, 1);
    expect_cycle(0, a);
    tick();
    req_valid = 0;
    chk(bus_start_n == 0 && bus_write == 0, "R2", "read start after take", bus_start_n, 0);
    chk(req_ready == 0, "R3", "ready while busy", req_ready, 0);
  endtask

  task automatic burst();
    tick();
    for (int i = 0; i < BEATS; i++) begin
      xfer_rdy_n = 0;
      xfer_last_n = (i == BEATS - 1) ? 1'b0 : 1'b1;
      tick();
      if (i < BEATS - 1)
        chk(upd_valid == 0 && fill_done == 0, "R7", "burst ended early", upd_valid | fill_done, 0);
    end
    xfer_rdy_n = 1; xfer_last_n = 1;
  endtask

  task automatic snoop_hit(logic [AW-1:0] a, bit inv, bit modified);
    snoop_strobe_n = 0; snoop_addr = a; snoop_inval = inv;
    mod_line = a[AW-1:LOFF]; mod_en = modified;
    tick();
    snoop_strobe_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] s;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk(bus_start_n == 1, "R1", "start idle", bus_start_n, 1);
    chk(snoop_mod_n == 1, "R1", "mod flag idle", snoop_mod_n, 1);
    chk(fill_done == 0 && upd_valid == 0, "R1", "pulses idle", fill_done | upd_valid, 0);
    chk(req_ready == 1, "R1", "ready idle", req_ready, 1);

    // R3 ready blocked by hold and by back-off
    addr_hold = 1; #1;
    chk(req_ready == 0, "R3", "ready under hold", req_ready, 0);
    addr_hold = 0; backoff_n = 0; #1;
    chk(req_ready == 0, "R3", "ready under back-off", req_ready, 0);
    backoff_n = 1; tick();

    // R2/R10 plain fill
    request(32'h0000_1240);
    burst();
    chk(fill_done == 1, "R10", "fill done pulse", fill_done, 1);
    tick();
    chk(fill_done == 0, "R10", "fill done one cycle", fill_done, 0);

    // R4 snoop on unmodified line leaves flag high
    addr_hold = 1; tick();
    snoop_hit(32'h0000_5550, 1, 0);
    chk(snoop_mod_n == 1, "R4", "no hit on clean line", snoop_mod_n, 1);
    addr_hold = 0; tick();
    chk(bus_start_n == 1, "R4", "no write-back on clean line", bus_start_n, 1);

    // main: hit during fill, back-off, hold released first then back-off
    request(32'h0000_2000);
    tick(); xfer_rdy_n = 0; tick(); xfer_rdy_n = 1;
    addr_hold = 1; tick();
    s = 32'h0000_ABC8;
    snoop_hit(s, 1, 1);
    chk(snoop_mod_n == 0, "R4", "hit on modified line", snoop_mod_n, 0);
    backoff_n = 0; tick();
    for (int k = 0; k < 3; k++) begin
      chk(bus_start_n == 1, "R5", "no start during back-off", bus_start_n, 1);
      tick();
    end
    addr_hold = 0; tick();
    chk(bus_start_n == 1, "R6", "still backed off", bus_start_n, 1);
    expect_cycle(1, {s[AW-1:LOFF], {LOFF{1'b0}}});
    expect_cycle(0, 32'h0000_2000);
    backoff_n = 1; tick();
    chk(bus_start_n == 0 && bus_write == 1, "R6", "write-back one cycle after release", bus_start_n, 0);
    chk(fill_done == 0, "R5", "aborted fill not done", fill_done, 0);
    burst();
    chk(upd_valid == 1 && upd_inval == 1, "R9", "invalidate update", {upd_valid, upd_inval}, 3);
    chk(upd_line == s[AW-1:LOFF], "R9", "update line", upd_line, s[AW-1:LOFF]);
    chk(bus_start_n == 0 && bus_write == 0, "R8", "replay read start", bus_start_n, 0);
    chk(snoop_mod_n == 1, "R8", "mod flag high at replay", snoop_mod_n, 1);
    burst();
    chk(fill_done == 1, "R10", "replayed fill done", fill_done, 1);
    tick();

    // back-off released first, hold later
    request(32'h0000_3300);
    tick();
    addr_hold = 1; tick();
    s = 32'h0000_7714;
    snoop_hit(s, 0, 1);
    backoff_n = 0; tick();
    backoff_n = 1; tick();
    chk(bus_start_n == 1, "R6", "held by address hold", bus_start_n, 1);
    expect_cycle(1, {s[AW-1:LOFF], {LOFF{1'b0}}});
    expect_cycle(0, 32'h0000_3300);
    addr_hold = 0; tick();
    chk(bus_start_n == 0 && bus_write == 1, "R6", "write-back after hold release", bus_start_n, 0);
    burst();
    chk(upd_valid == 1 && upd_inval == 0, "R9", "shared update", {upd_valid, upd_inval}, 2);
    chk(bus_start_n == 0 && bus_write == 0, "R8", "replay after hold release", bus_start_n, 0);
    burst();
    tick();

    // R11 hit while idle, no back-off, no replay
    addr_hold = 1; tick();
    s = 32'h0000_9990;
    snoop_hit(s, 0, 1);
    chk(snoop_mod_n == 0, "R11", "idle hit flag", snoop_mod_n, 0);
    chk(req_ready == 0, "R3", "ready while write-back owed", req_ready, 0);
    expect_cycle(1, {s[AW-1:LOFF], {LOFF{1'b0}}});
    addr_hold = 0; tick();
    chk(bus_start_n == 0 && bus_write == 1, "R11", "idle write-back start", bus_start_n, 0);
    burst();
    chk(upd_valid == 1 && upd_inval == 0, "R11", "idle update shared", {upd_valid, upd_inval}, 2);
    chk(bus_start_n == 1 && snoop_mod_n == 1, "R11", "no replay after idle write-back", bus_start_n, 1);
    tick();
    chk(req_ready == 1, "R11", "back to idle", req_ready, 1);

    chk(exp_q.size() == 0, "R2", "all expected bus cycles seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule